// File: doc/BRIEF.md
# Carry-First Select Adder

This is a purely combinational adder of configurable width. It takes two operands and a carry-in and returns their sum and carry-out. It first forms a per-bit propagate word (XOR) and a per-bit generate word (AND). From these it builds two complete carry words side by side, one that assumes an incoming carry of zero and one that assumes an incoming carry of one.

Only after both carry words exist does the real carry-in choose between them. No sum is computed for either assumption. A single XOR row then combines the propagate word with the chosen carry word, shifted up by one position. Bit 0 of that row takes the carry-in directly.

The choice between the two carry words needs no multiplexer. Whenever the zero-assumption carry is set at some bit, the one-assumption carry is also set there. So each selected bit is the zero-assumption carry ORed with the one-assumption carry gated by the carry-in.

Top module: `csel_carry_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals a + b + cin taken as an unsigned value of W+1 bits.
- R2: When a AND b is zero and cin is 0, sum equals a XOR b and cout is 0, so no carry is created anywhere.
- R3: Bit 0 of the zero-assumption carry word equals a[0] AND b[0]. Bit 0 of the one-assumption carry word equals a[0] OR b[0].
- R4: At every bit position, a set bit in the zero-assumption carry word implies a set bit in the one-assumption carry word.
- R5: The selected carry word equals the zero-assumption word when cin is 0 and the one-assumption word when cin is 1. A carry-in of 1 into an all-propagate operand pair therefore ripples through every bit.
- R6: cout is the carry out of the most significant bit. It is 1 exactly when a + b + cin reaches 2^W.
- R7: sum[0] equals a[0] XOR b[0] XOR cin. Every higher sum bit i uses the selected carry of bit i-1.
- R8: The width W is a parameter, and the behaviour above holds at W = 4, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The adder holds no state, so each result is due in the same cycle as the stimulus that causes it, after zero clock edges. The bench changes the operands just after a rising edge and reads sum and cout at the following falling edge. That leaves half a period for the logic to settle, and no sample coincides with an input change. Long ripple cases set every bit to propagate so that the carry-in must travel from bit 0 to cout. Width 4 is swept over every input combination.

// File: rtl/csel_carry_adder.sv
module csel_carry_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W-1:0] hs;
  logic [W-1:0] hc;
  logic [W-1:0] cz;
  logic [W-1:0] co;
  logic [W-1:0] csel;

  assign hs = a ^ b;
  assign hc = a & b;

  assign cz[0] = hc[0];
  assign co[0] = hs[0] | hc[0];

  for (genvar i = 1; i < W; i++) begin : g_chain
    assign cz[i] = (cz[i-1] & hs[i]) | hc[i];
    assign co[i] = (co[i-1] & hs[i]) | hc[i];
  end

  assign csel = cz | ({W{cin}} & co);

  assign sum  = hs ^ {csel[W-2:0], cin};
  assign cout = csel[W-1];

endmodule

// File: rtl/csel_carry_adder_chk.sv
module csel_carry_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic [W-1:0] cz,
  input logic [W-1:0] co,
  input logic [W-1:0] csel
);

  logic [W:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    p_total_r1: assert ({cout, sum} == ref_total)
      else $error("total mismatch");
    p_base_bits_r3: assert (cz[0] == (a[0] & b[0]) && co[0] == (a[0] | b[0]))
      else $error("chain base mismatch");
    p_imply_r4: assert ((cz & ~co) == '0)
      else $error("carry implication broken");
    p_select_r5: assert (csel == (cin ? co : cz))
      else $error("carry selection mismatch");
    p_low_bit_r7: assert (sum[0] == (a[0] ^ b[0] ^ cin))
      else $error("sum bit 0 mismatch");
  end

endmodule

bind csel_carry_adder csel_carry_adder_chk #(.W(W)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .cz(cz), .co(co), .csel(csel)
);

// File: tb/csel_carry_adder_test.sv
module csel_carry_adder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]  a4, b4, s4;
  logic        ci4, co4;
  logic [15:0] a16, b16, s16;
  logic        ci16, co16;
  logic [31:0] a32, b32, s32;
  logic        ci32, co32;

  csel_carry_adder #(.W(4))  uut4  (.a(a4),  .b(b4),  .cin(ci4),  .sum(s4),  .cout(co4));
  csel_carry_adder #(.W(16)) uut   (.a(a16), .b(b16), .cin(ci16), .sum(s16), .cout(co16));
  csel_carry_adder #(.W(32)) uut32 (.a(a32), .b(b32), .cin(ci32), .sum(s32), .cout(co32));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive16(input logic [15:0] x, input logic [15:0] y, input logic c);
    @(posedge clk); a16 <= x; b16 <= y; ci16 <= c;
    @(negedge clk);
  endtask

  task automatic drive32(input logic [31:0] x, input logic [31:0] y, input logic c);
    @(posedge clk); a32 <= x; b32 <= y; ci32 <= c;
    @(negedge clk);
  endtask

  task automatic t_idle_zero;
    @(negedge clk);
    chk("R1 zero w16", {47'd0, co16, s16}, 64'd0);
    chk("R1 zero w32", {31'd0, co32, s32}, 64'd0);
    chk("R1 zero w4",  {59'd0, co4, s4},   64'd0);
  endtask

  task automatic t_sweep4;
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          @(posedge clk); a4 <= 4'(x); b4 <= 4'(y); ci4 <= 1'(c);
          @(negedge clk);
          chk("R8 R1 w4 sweep", {59'd0, co4, s4}, 64'(x + y + c));
        end
  endtask

  task automatic t_no_generate;
    drive16(16'hA5A5, 16'h5A5A, 1'b0);
    chk("R2 disjoint w16", {47'd0, co16, s16}, {47'd0, 1'b0, 16'hFFFF});
    drive32(32'h0F0F_1234, 32'h40F0_4001, 1'b0);
    chk("R2 disjoint w32", {31'd0, co32, s32}, {31'd0, 1'b0, 32'h4FFF_5235});
  endtask

  task automatic t_base_bit;
    drive16(16'h0001, 16'h0001, 1'b0);
    chk("R3 generate at bit0", {47'd0, co16, s16}, 64'h2);
    drive16(16'h0001, 16'h0000, 1'b1);
    chk("R3 propagate at bit0", {47'd0, co16, s16}, 64'h2);
  endtask

  task automatic t_ripple;
    drive16(16'hFFFF, 16'h0000, 1'b1);
    chk("R5 R6 full ripple w16", {47'd0, co16, s16}, 64'h1_0000);
    drive16(16'hFFFF, 16'h0000, 1'b0);
    chk("R5 no ripple w16", {47'd0, co16, s16}, 64'h0_FFFF);
    drive32(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    chk("R5 R6 full ripple w32", {31'd0, co32, s32}, 64'h1_0000_0000);
    drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk("R4 R6 all ones w32", {31'd0, co32, s32}, 64'h1_FFFF_FFFF);
    drive32(32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R6 top generate w32", {31'd0, co32, s32}, 64'h1_0000_0000);
  endtask

  task automatic t_low_bit;
    for (int c = 0; c < 2; c++) begin
      drive16(16'h0000, 16'h0001, 1'(c));
      chk("R7 sum bit0", {63'd0, s16[0]}, {63'd0, 1'(1 ^ c)});
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++) begin
      logic [15:0] x = 16'($urandom);
      logic [15:0] y = 16'($urandom);
      logic        c = 1'($urandom);
      logic [31:0] p = $urandom;
      logic [31:0] q = $urandom;
      drive16(x, y, c);
      chk("R1 random w16", {47'd0, co16, s16}, 64'(x) + 64'(y) + 64'(c));
      drive32(p, q, c);
      chk("R8 R1 random w32", {31'd0, co32, s32}, 64'(p) + 64'(q) + 64'(c));
    end
  endtask

  initial begin
    a4 = '0; b4 = '0; ci4 = 1'b0;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle_zero();
    t_sweep4();
    t_no_generate();
    t_base_bit();
    t_ripple();
    t_low_bit();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule